// File: doc/BRIEF.md
# Tagged Memory Permission Checker

This block sits in front of physical memory and decides whether each access may go ahead. Every memory word carries a 32-bit tag, which arrives with the request. A permission table held outside the block maps each tag to three rights: read, write and execute. The checker keeps two small caches of recent tag-to-rights entries. One serves instruction fetches and the other serves loads and stores. Processor accesses and device accesses are judged by the same table.

One request is in flight at a time. On a cache hit the verdict appears one cycle after the request is accepted. A granted access is passed on with its address. A denied access raises a fault that carries the address and access type, and it is never passed on. On a miss the checker stalls and asks the backing table for the tag's rights. It installs the reply in the cache and then repeats the check.

Only trusted software may change permissions. A write on the programming port counts only when it is marked trusted. It then removes any cached copy of that tag from both caches, so the next access fetches the new rights. Untrusted writes are ignored.

Top module: `tag_perm_checker`

## Requirements
- R1: After reset `req_ready` is 1 and `resp_grant`, `resp_fault` and `fill_req` are 0.
- R2: Rights are three bits: bit 0 allows read, bit 1 allows write, bit 2 allows execute. Access type is coded 0 read, 1 write, 2 execute. An access that hits is granted only when the bit for its type is set. `resp_grant` pulses one cycle after acceptance, with `resp_addr` and `resp_type` set to the request's values.
- R3: A denied access pulses `resp_fault` with the request's address and type, and `resp_grant` stays 0. Grant and fault are never asserted together.
- R4: Access type 3 always faults. An execute request from a device (`req_dev`=1) always faults. Neither case issues a fill.
- R5: On a miss `req_ready` drops and `fill_req` rises with `fill_tag` equal to the request tag. Both hold until `fill_valid`. After the fill the check is retried and answered with the returned rights. A later access to the same tag on the same side hits and issues no fill.
- R6: Execute requests look up the instruction cache, and read and write requests look up the data cache. An entry filled on one side does not satisfy a lookup on the other side.
- R7: Each cache has ENTRIES slots, which default to 8. Slots are replaced in round-robin order, so after ENTRIES+1 distinct tags have been filled on one side, the first of them misses again.
- R8: A trusted write on the programming port invalidates the cached entries for that tag in both caches. The next access to that tag issues a fill.
- R9: A programming write with `prog_trusted`=0 has no effect: the next access to a cached tag hits and keeps the old rights.
- R10: Device reads and writes are checked against the same rights as processor accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Checker can accept a request |
| req_addr | input | ADDR_W | Physical address of the access |
| req_tag | input | TAG_W | Tag of the addressed word |
| req_type | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| req_dev | input | 1 | Request comes from a device |
| prog_valid | input | 1 | Permission table write |
| prog_trusted | input | 1 | Write issued by trusted software |
| prog_tag | input | TAG_W | Tag whose permission entry is written |
| fill_req | output | 1 | Rights requested from the backing table |
| fill_tag | output | TAG_W | Tag being requested |
| fill_valid | input | 1 | Backing table reply present |
| fill_rights | input | 3 | Rights returned for `fill_tag` |
| resp_grant | output | 1 | Access granted and forwarded |
| resp_fault | output | 1 | Access denied |
| resp_addr | output | ADDR_W | Address of the judged access |
| resp_type | output | 2 | Type of the judged access |

## Verification
The bench targets the corner cases a cache can get wrong:
- **Crossover between the two caches.** A design that shares one cache between fetches and data accesses would not issue a fill when the same tag is first used for execute.
- **Eviction order.** Re-reading the first tag after nine fills on one side shows this. A design that never evicts, or evicts the wrong slot, would hit where it should miss.
- **Invalidation.** A design that ignores `prog_trusted` would refetch after an untrusted write. One that misses the invalidation would keep granting with stale rights.
- **Reserved types and device fetches.** If these reached the cache, they would either start a fill or be granted.

Random traffic over twelve tags mixes evictions with table rewrites and checks every verdict against a model of the table.

// File: rtl/tag_perm_checker.sv
module tag_perm_checker #(
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 32,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [1:0]        req_type,
  input  logic              req_dev,
  input  logic              prog_valid,
  input  logic              prog_trusted,
  input  logic [TAG_W-1:0]  prog_tag,
  output logic              fill_req,
  output logic [TAG_W-1:0]  fill_tag,
  input  logic              fill_valid,
  input  logic [2:0]        fill_rights,
  output logic              resp_grant,
  output logic              resp_fault,
  output logic [ADDR_W-1:0] resp_addr,
  output logic [1:0]        resp_type
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_RETRY} st_t;
  st_t st;

  logic [ADDR_W-1:0] h_addr;
  logic [TAG_W-1:0]  h_tag;
  logic [1:0]        h_type;
  logic              h_dev;

  logic [TAG_W-1:0]   c_tag [2][ENTRIES];
  logic [2:0]         c_rw  [2][ENTRIES];
  logic [ENTRIES-1:0] c_vld [2];
  logic [IW-1:0]      rr    [2];

  wire accept = (st == S_IDLE) && req_valid;
  wire check  = accept || (st == S_RETRY);

  wire [ADDR_W-1:0] cur_addr = (st == S_IDLE) ? req_addr : h_addr;
  wire [TAG_W-1:0]  cur_tag  = (st == S_IDLE) ? req_tag  : h_tag;
  wire [1:0]        cur_type = (st == S_IDLE) ? req_type : h_type;
  wire              cur_dev  = (st == S_IDLE) ? req_dev  : h_dev;
  wire              cur_side = (cur_type == 2'd2);

  logic       hit;
  logic [2:0] hit_rw;
  always_comb begin
    hit    = 1'b0;
    hit_rw = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (c_vld[cur_side][i] && c_tag[cur_side][i] == cur_tag) begin
        hit    = 1'b1;
        hit_rw = c_rw[cur_side][i];
      end
  end

  wire bad = (cur_type == 2'd3) || (cur_dev && cur_type == 2'd2);

  logic allowed;
  always_comb begin
    case (cur_type)
      2'd0:    allowed = hit_rw[0];
      2'd1:    allowed = hit_rw[1];
      2'd2:    allowed = hit_rw[2];
      default: allowed = 1'b0;
    endcase
    if (bad) allowed = 1'b0;
  end

  wire resolve   = check && (bad || hit);
  wire fill_side = (h_type == 2'd2);
  wire inv       = prog_valid && prog_trusted;
  wire install   = (st == S_FILL) && fill_valid && !(inv && prog_tag == h_tag);

  assign req_ready = (st == S_IDLE);
  assign fill_req  = (st == S_FILL);
  assign fill_tag  = h_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      resp_grant <= 1'b0;
      resp_fault <= 1'b0;
      resp_addr  <= '0;
      resp_type  <= '0;
      h_addr     <= '0;
      h_tag      <= '0;
      h_type     <= '0;
      h_dev      <= 1'b0;
      for (int s = 0; s < 2; s++) begin
        c_vld[s] <= '0;
        rr[s]    <= '0;
      end
    end else begin
      resp_grant <= 1'b0;
      resp_fault <= 1'b0;
      if (accept) begin
        h_addr <= req_addr;
        h_tag  <= req_tag;
        h_type <= req_type;
        h_dev  <= req_dev;
      end
      case (st)
        S_IDLE:  if (accept && !resolve) st <= S_FILL;
        S_FILL:  if (fill_valid) st <= S_RETRY;
        S_RETRY: st <= resolve ? S_IDLE : S_FILL;
        default: st <= S_IDLE;
      endcase
      if (resolve) begin
        resp_grant <= allowed;
        resp_fault <= !allowed;
        resp_addr  <= cur_addr;
        resp_type  <= cur_type;
      end
      if (inv)
        for (int s = 0; s < 2; s++)
          for (int i = 0; i < ENTRIES; i++)
            if (c_tag[s][i] == prog_tag) c_vld[s][i] <= 1'b0;
      if (install) begin
        c_tag[fill_side][rr[fill_side]] <= h_tag;
        c_rw[fill_side][rr[fill_side]]  <= fill_rights;
        c_vld[fill_side][rr[fill_side]] <= 1'b1;
        rr[fill_side] <= (rr[fill_side] == IW'(ENTRIES - 1)) ? '0 : rr[fill_side] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tag_perm_checker_chk.sv
module tag_perm_checker_chk #(
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 32,
  parameter int ENTRIES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [TAG_W-1:0]  req_tag,
  input logic [1:0]        req_type,
  input logic              req_dev,
  input logic              prog_valid,
  input logic              prog_trusted,
  input logic [TAG_W-1:0]  prog_tag,
  input logic              fill_req,
  input logic [TAG_W-1:0]  fill_tag,
  input logic              fill_valid,
  input logic [2:0]        fill_rights,
  input logic              resp_grant,
  input logic              resp_fault,
  input logic [ADDR_W-1:0] resp_addr,
  input logic [1:0]        resp_type
);
  // R3
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_grant && resp_fault));

  // R5
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_valid) |=> (fill_req && $stable(fill_tag)));

  // R5
  stall_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);

  // R4
  reserved_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_type == 2'd3) |=> (resp_fault && !resp_grant && !fill_req));

  // R4
  dev_fetch_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_dev && req_type == 2'd2) |=> (resp_fault && !fill_req));
endmodule

bind tag_perm_checker tag_perm_checker_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/tag_perm_checker_tb.sv
module tag_perm_checker_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_ready;
  logic [31:0] req_addr = 0, req_tag = 0;
  logic [1:0]  req_type = 0;
  logic        req_dev = 0;
  logic        prog_valid = 0, prog_trusted = 0;
  logic [31:0] prog_tag = 0;
  logic        fill_req;
  logic [31:0] fill_tag;
  logic        fill_valid = 0;
  logic [2:0]  fill_rights = 0;
  logic        resp_grant, resp_fault;
  logic [31:0] resp_addr;
  logic [1:0]  resp_type;

  int tests = 0, fails = 0, cyc = 0;
  logic [2:0] ovr [logic [31:0]];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  tag_perm_checker u_dut (.*);

  function automatic logic [2:0] rights_of(input logic [31:0] t);
    if (ovr.exists(t)) return ovr[t];
    return t[2:0] ^ t[10:8];
  endfunction

  function automatic logic exp_grant(input logic [31:0] t, input logic [1:0] ty, input logic dv);
    if (ty == 2'd3 || (dv && ty == 2'd2)) return 1'b0;
    return rights_of(t)[ty];
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [31:0] t, input logic tr, input logic [2:0] r);
    @(negedge clk);
    prog_valid = 1; prog_tag = t; prog_trusted = tr;
    @(negedge clk);
    prog_valid = 0; prog_trusted = 0;
    if (tr) ovr[t] = r;
  endtask

  task automatic access(input logic [31:0] a, input logic [31:0] t, input logic [1:0] ty, input logic dv,
                        output logic g, output logic f, output logic m);
    g = 0; f = 0; m = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_tag = t; req_type = ty; req_dev = dv;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 60; k++) begin
      if (resp_grant || resp_fault) begin
        g = resp_grant; f = resp_fault;
        chk(resp_addr == a, "R3 resp_addr", resp_addr, a);
        chk(resp_type == ty, "R3 resp_type", resp_type, ty);
        break;
      end
      if (fill_req && !fill_valid) begin
        m = 1;
        if (fill_tag != t) chk(0, "R5 fill_tag", fill_tag, t);
        fill_valid = 1; fill_rights = rights_of(t);
      end else fill_valid = 0;
      @(negedge clk);
    end
    fill_valid = 0;
  endtask

  task automatic acc_chk(input logic [31:0] t, input logic [1:0] ty, input logic dv,
                         input int exp_miss, input string req);
    logic g, f, m, e;
    logic [31:0] a;
    a = $urandom;
    access(a, t, ty, dv, g, f, m);
    e = exp_grant(t, ty, dv);
    chk(g == e && f == !e, req, {g, f}, {e, !e});
    if (exp_miss >= 0) chk(m == exp_miss[0], {req, " miss"}, m, exp_miss[0]);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_grant && !resp_fault && !fill_req, "R1 reset",
        {req_ready, resp_grant, resp_fault, fill_req}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !fill_req, "R1 after reset", {req_ready, fill_req}, 2'b10);

    ovr[32'h100] = 3'b001;
    acc_chk(32'h100, 2'd0, 0, 1, "R5 first read misses, R2 grant");
    acc_chk(32'h100, 2'd0, 0, 0, "R5 second read hits");
    acc_chk(32'h100, 2'd1, 0, 0, "R3 write denied");
    acc_chk(32'h100, 2'd2, 0, 1, "R6 fetch uses instruction cache");
    acc_chk(32'h100, 2'd0, 1, 0, "R10 device read");
    acc_chk(32'h100, 2'd1, 1, 0, "R10 device write denied");
    acc_chk(32'h100, 2'd2, 1, 0, "R4 device fetch");
    acc_chk(32'h100, 2'd3, 0, 0, "R4 reserved type");

    prog(32'h100, 1, 3'b010);
    acc_chk(32'h100, 2'd1, 0, 1, "R8 trusted write refetches");
    acc_chk(32'h100, 2'd2, 0, 1, "R8 instruction side invalidated");
    prog(32'h100, 0, 3'b000);
    acc_chk(32'h100, 2'd1, 0, 0, "R9 untrusted write ignored");

    for (int i = 0; i < 9; i++) begin
      ovr[32'h300 + i] = 3'b001;
      acc_chk(32'h300 + i, 2'd0, 0, 1, "R7 fill");
    end
    acc_chk(32'h300, 2'd0, 0, 1, "R7 oldest evicted");
    acc_chk(32'h302, 2'd0, 0, 0, "R7 newer kept");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] t;
      logic [1:0] ty;
      t  = 32'h200 + ($urandom % 12);
      ty = 2'($urandom % 4);
      if ($urandom % 8 == 0) prog(t, 1'($urandom % 2), 3'($urandom));
      acc_chk(t, ty, ($urandom % 4) == 0, -1, "R2 random verdict");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc == 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected 0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule